// File: doc/BRIEF.md
# Sticky error status register

This block holds the eight error flags of a serial bus controller. The transmitter and receiver report each error as a one-cycle event. The block samples those events only on prescaler ticks and latches each one into its own bit. Software reads the flags through a single-cycle read strobe. The value on `status_o` during the read cycle is the value read. Any clearing that the read causes takes effect on the following clock edge.

Each bit has its own rule for clearing:
- The timeout bit ignores reads. It clears only when the peripheral is switched off.
- The break bit clears on a read only when the break is no longer present on the line.
- The other six bits clear on a read, but only if they were already set when the read occurred.
- Switching the peripheral off, with the enable bit low or the disable bit high, zeroes the whole register.

Four receiver conditions also drive live level outputs so that the receive path can act on them: break, CRC error, framing error and bit error. Each level stays high from its event until a valid end-of-frame strobe arrives on a tick. The logic that detects each error is not part of this block.

Top module: `err_status_reg`

## Requirements
- R1: After reset `status_o` and `cond_o` are zero. The bits of `status_o`, from bit 7 down to bit 0, are: timeout, underflow, overrun, arbitration loss, break, CRC error, framing error, bit error. `evt_i[n]` is the event for `status_o[n]`.
- R2: While the block is active (`en_i`=1 and `dis_i`=0), `evt_i[n]` sets `status_o[n]` on the next clock edge only if `tick_i` is high in the same cycle. Without a tick the event is ignored.
- R3: A read (`rd_i`=1) clears bits 6, 5, 4, 2, 1 and 0 one clock later, but only the bits that were set during the read cycle. `status_o` during the read cycle shows the value before the read. An event that is ticked in the read cycle leaves its bit set.
- R4: A read leaves bit 7 (timeout) unchanged.
- R5: A read clears bit 3 (break) only if `brk_active_i` is low in the read cycle. A read made while `brk_active_i` is high leaves the bit set.
- R6: While `en_i`=0 or `dis_i`=1, `status_o` and `cond_o` are held at zero, and events are ignored.
- R7: `cond_o[k]` for k in 0..3 follows bit k of the register. It sets on a ticked `evt_i[k]` and ignores reads. It clears only when `eof_i` and `tick_i` are both high with no new event for that condition; an end-of-frame strobe without a tick has no effect. Events on bits 4 to 7 drive no condition level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Peripheral enable control bit |
| dis_i | input | 1 | Peripheral disable control bit |
| tick_i | input | 1 | Prescaled clock enable |
| evt_i | input | 8 | One-cycle error events, one per status bit |
| eof_i | input | 1 | Valid end-of-frame strobe |
| brk_active_i | input | 1 | Live break condition on the line |
| rd_i | input | 1 | Register read strobe |
| status_o | output | 8 | Sticky error register value |
| cond_o | output | 4 | Live condition levels: break, CRC, framing, bit |

## Verification
The bench fires a ticked event in the same cycle as a read. A design that lets the clear win would lose that error. It reads the timeout bit and the break bit under each of their blocking conditions. A design with a uniform clear-on-read rule would drop them there.

Events and end-of-frame strobes are also sent without a tick. A design that is not gated by the prescaler would latch those events or drop the condition levels. The enable and disable bits are toggled with flags set. A design that only blocked new events, without clearing the existing flags, would keep the old flags visible.

// File: rtl/err_status_pkg.sv
package err_status_pkg;
  localparam int unsigned NUM_BITS = 8;
  localparam int unsigned NUM_COND = 4;

  localparam int unsigned BIT_TIMEOUT = 7;
  localparam int unsigned BIT_BREAK   = 3;

  typedef enum logic [1:0] {
    CLR_ON_READ   = 2'd0,
    CLR_NEVER     = 2'd1,
    CLR_READ_IDLE = 2'd2
  } clr_policy_e;

  function automatic clr_policy_e policy_of(int unsigned idx);
    if (idx == BIT_TIMEOUT) return CLR_NEVER;
    if (idx == BIT_BREAK)   return CLR_READ_IDLE;
    return CLR_ON_READ;
  endfunction
endpackage

// File: rtl/err_sticky_bit.sv
module err_sticky_bit
  import err_status_pkg::*;
#(
  parameter clr_policy_e POLICY = CLR_ON_READ
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic set_i,
  input  logic rd_i,
  input  logic hold_i,
  output logic q_o
);
  logic q_q;
  logic clr_allow;

  generate
    if (POLICY == CLR_NEVER) begin : g_never
      assign clr_allow = 1'b0;
    end else if (POLICY == CLR_READ_IDLE) begin : g_idle
      assign clr_allow = ~hold_i;
    end else begin : g_read
      assign clr_allow = 1'b1;
    end
  endgenerate

  // set has priority so a same-cycle event survives the read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        q_q <= 1'b0;
    else if (!active_i) q_q <= 1'b0;
    else if (set_i)     q_q <= 1'b1;
    else if (rd_i && clr_allow) q_q <= 1'b0;
  end

  assign q_o = q_q;

  p_set_holds_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && set_i) |=> (q_o || !active_i));

  p_idle_no_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!q_o && !set_i) |=> !q_o);

  generate
    if (POLICY == CLR_NEVER) begin : g_a_never
      p_timeout_ignores_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (active_i && q_o && rd_i) |=> (q_o || !active_i));
    end else if (POLICY == CLR_READ_IDLE) begin : g_a_idle
      p_break_held_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (active_i && q_o && rd_i && hold_i) |=> (q_o || !active_i));
    end else begin : g_a_read
      p_read_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q_o && rd_i && !set_i) |=> !q_o);
    end
  endgenerate
endmodule

// File: rtl/err_cond_level.sv
module err_cond_level (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic set_i,
  input  logic end_i,
  output logic lvl_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        lvl_q <= 1'b0;
    else if (!active_i) lvl_q <= 1'b0;
    else if (set_i)     lvl_q <= 1'b1;
    else if (end_i)     lvl_q <= 1'b0;
  end

  assign lvl_o = lvl_q;

  p_eof_drops_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_i && !set_i) |=> !lvl_o);

  p_level_holds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && lvl_o && !end_i) |=> (lvl_o || !active_i));
endmodule

// File: rtl/err_status_reg.sv
module err_status_reg
  import err_status_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                dis_i,
  input  logic                tick_i,
  input  logic [NUM_BITS-1:0] evt_i,
  input  logic                eof_i,
  input  logic                brk_active_i,
  input  logic                rd_i,
  output logic [NUM_BITS-1:0] status_o,
  output logic [NUM_COND-1:0] cond_o
);
  logic                active;
  logic [NUM_BITS-1:0] set_vec;
  logic                eof_tick;

  assign active   = en_i & ~dis_i;
  assign set_vec  = evt_i & {NUM_BITS{tick_i}};
  assign eof_tick = eof_i & tick_i;

  for (genvar b = 0; b < NUM_BITS; b++) begin : g_bit
    err_sticky_bit #(.POLICY(policy_of(b))) u_bit (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .active_i (active),
      .set_i    (set_vec[b]),
      .rd_i     (rd_i),
      .hold_i   (brk_active_i),
      .q_o      (status_o[b])
    );
  end

  for (genvar k = 0; k < NUM_COND; k++) begin : g_cond
    err_cond_level u_cond (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .active_i (active),
      .set_i    (set_vec[k]),
      .end_i    (eof_tick),
      .lvl_o    (cond_o[k])
    );
  end

  p_off_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |=> (status_o == '0 && cond_o == '0));

  p_no_tick_no_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && status_o == '0) |=> (status_o == '0));
endmodule

// File: tb/err_status_reg_tb.sv
module err_status_reg_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, dis = 1'b0, tick = 1'b0, eof = 1'b0, brk = 1'b0, rd = 1'b0;
  logic [7:0] evt = '0;
  logic [7:0] status;
  logic [3:0] cond;
  int         n_chk = 0, n_err = 0;
  bit         done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  err_status_reg u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .dis_i(dis), .tick_i(tick),
    .evt_i(evt), .eof_i(eof), .brk_active_i(brk), .rd_i(rd),
    .status_o(status), .cond_o(cond)
  );

  task automatic chk8(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  // drive one cycle at negedge, return at next negedge with outputs settled
  task automatic cyc(logic t, logic [7:0] e, logic f, logic r);
    @(negedge clk);
    tick = t; evt = e; eof = f; rd = r;
    @(negedge clk);
    tick = 0; evt = '0; eof = 0; rd = 0;
  endtask

  task automatic off_on();
    @(negedge clk); en = 0;
    @(negedge clk); en = 1;
  endtask

  task automatic t_reset();
    chk8("R1 status", status, 8'h00);
    chk8("R1 cond", {4'h0, cond}, 8'h00);
  endtask

  task automatic t_tick_gate();
    cyc(0, 8'hFF, 0, 0);
    chk8("R2 no tick", status, 8'h00);
    cyc(1, 8'h41, 0, 0);
    chk8("R2 ticked", status, 8'h41);
    cyc(1, 8'h22, 0, 0);
    chk8("R2 accumulate", status, 8'h63);
    off_on();
  endtask

  task automatic t_read_clear();
    cyc(1, 8'h77, 0, 0);
    chk8("R3 pre-read", status, 8'h77);
    cyc(0, 8'h00, 0, 1);
    chk8("R3 after read", status, 8'h00);
    cyc(1, 8'h40, 0, 0);
    cyc(1, 8'h24, 0, 1);
    chk8("R3 same-cycle event", status, 8'h24);
    cyc(0, 8'h00, 0, 1);
    chk8("R3 second read", status, 8'h00);
    off_on();
  endtask

  task automatic t_timeout();
    cyc(1, 8'hC0, 0, 0);
    cyc(0, 8'h00, 0, 1);
    chk8("R4 timeout survives read", status, 8'h80);
    cyc(0, 8'h00, 0, 1);
    chk8("R4 second read", status, 8'h80);
    off_on();
    chk8("R4 cleared by disable", status, 8'h00);
  endtask

  task automatic t_break();
    @(negedge clk); brk = 1;
    cyc(1, 8'h08, 0, 0);
    cyc(0, 8'h00, 0, 1);
    chk8("R5 read during break", status, 8'h08);
    @(negedge clk); brk = 0;
    cyc(0, 8'h00, 0, 1);
    chk8("R5 read after break", status, 8'h00);
    off_on();
  endtask

  task automatic t_disable();
    cyc(1, 8'hFF, 0, 0);
    chk8("R6 all set", status, 8'hFF);
    @(negedge clk); dis = 1;
    @(negedge clk);
    chk8("R6 dis zeroes status", status, 8'h00);
    chk8("R6 dis zeroes cond", {4'h0, cond}, 8'h00);
    cyc(1, 8'hFF, 0, 0);
    chk8("R6 events ignored", status, 8'h00);
    @(negedge clk); dis = 0;
    cyc(1, 8'h10, 0, 0);
    @(negedge clk); en = 0;
    @(negedge clk);
    chk8("R6 en low zeroes", status, 8'h00);
    @(negedge clk); en = 1;
  endtask

  task automatic t_cond();
    cyc(1, 8'h1A, 0, 0);
    chk8("R7 levels set, arb none", {4'h0, cond}, 8'h0A);
    cyc(0, 8'h00, 0, 1);
    chk8("R7 levels ignore read", {4'h0, cond}, 8'h0A);
    cyc(0, 8'h00, 1, 0);
    chk8("R7 eof without tick", {4'h0, cond}, 8'h0A);
    cyc(1, 8'h01, 1, 0);
    chk8("R7 eof tick, new event stays", {4'h0, cond}, 8'h01);
    cyc(1, 8'h00, 1, 0);
    chk8("R7 eof tick clears", {4'h0, cond}, 8'h00);
    off_on();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1; en = 1;
    @(negedge clk);
    t_reset();
    t_tick_gate();
    t_read_clear();
    t_timeout();
    t_break();
    t_disable();
    t_cond();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule